// File: doc/BRIEF.md
# Hart Timer Compare Unit

This block keeps a 64-bit machine time count for one hart and turns it into three timer interrupt pending levels: a machine timer, a supervisor timer and a virtual-supervisor timer. Each level comes from an unsigned greater-or-equal test of an effective time against a compare register. For the machine and supervisor tests the effective time is the count itself. For the virtual-supervisor test it is the count plus a hypervisor offset, kept to 64 bits so that the carry is lost.

Software loads the count, the three compare registers and the offset through one write port. Each write picks a register with a select code and picks halves with a two-bit mask. The count advances by one on every tick-enable pulse. The pending levels are worked out combinationally from the registered values. Because of that, a write to any register, and the count in particular, shows up on all three levels in the cycle after the write. The supervisor copy of time is a read-only mirror of the machine count.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset the count and the offset are zero and all three compare registers hold all-ones, so every pending output is low.
- R2: When tickEn is high and no write targets the count, the count grows by exactly one at the clock edge and wraps from all-ones to zero.
- R3: A write to the count (select 0 with a non-zero mask) in the same cycle as tickEn loads the written value and skips the increment.
- R4: mPendMtimer is high exactly when the count is unsigned greater than or equal to the machine compare register (select 1).
- R5: The supervisor pending level is high exactly when the count is unsigned greater than or equal to the supervisor compare register (select 2), and it drives both mPendStimer and sPendStimer with equal values.
- R6: hPendVstimer is high exactly when (count + offset) mod 2^64 is unsigned greater than or equal to the virtual-supervisor compare register (select 3). The offset is select 4, and the carry out of bit 63 is dropped.
- R7: superTime always equals machTime.
- R8: A write to the count alone updates all three pending outputs in the cycle after the write, with no compare write needed.
- R9: wrMask bit 0 writes bits 31:0 and wrMask bit 1 writes bits 63:32 of the selected register. A half that is not selected keeps its value.
- R10: A write with select 5, 6 or 7, or with a zero mask, changes no register.
- R11: Raising a compare register above the effective time clears its pending output in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advances the count by one |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 3 | Register select: 0 count, 1 machine compare, 2 supervisor compare, 3 virtual-supervisor compare, 4 offset |
| wrMask | input | 2 | Half select: bit 0 low word, bit 1 high word |
| wrData | input | 64 | Write data |
| machTime | output | 64 | Machine time count |
| superTime | output | 64 | Read-only supervisor copy of the count |
| mPendMtimer | output | 1 | Machine timer pending |
| mPendStimer | output | 1 | Supervisor timer pending, machine view |
| sPendStimer | output | 1 | Supervisor timer pending, supervisor view |
| hPendVstimer | output | 1 | Virtual-supervisor timer pending, hypervisor view |

## Verification
Every register update, whether from a write or from a tick, takes effect at the clock edge where it is presented. The count output and all four pending outputs follow from it combinationally, so each result is due one edge after its stimulus. The bench drives inputs at the falling edge, waits for the next rising edge and samples one nanosecond later, before any new stimulus is driven. A write to the count then shows its effect on the three comparisons in that same sample, and so does a compare-only write.

// File: rtl/htimer_pkg.sv
package htimer_pkg;
  localparam int TIME_W   = 64;
  localparam int HALF_W   = TIME_W / 2;
  localparam int NUM_REGS = 5;
  localparam int SEL_W    = 3;

  // register select codes
  localparam int SEL_TIME  = 0;
  localparam int SEL_MCMP  = 1;
  localparam int SEL_SCMP  = 2;
  localparam int SEL_VSCMP = 3;
  localparam int SEL_OFFS  = 4;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrLo;
    logic [NUM_REGS-1:0] wrHi;
    logic                tickInc;
  } strobe_t;
endpackage

// File: rtl/htimer_ctrl.sv
module htimer_ctrl
  import htimer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [1:0]       wrMask,
  output strobe_t          strb
);
  logic [NUM_REGS-1:0] regHit;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign regHit[i]      = wrEn && (wrSel == SEL_W'(i));
      assign strb.wrLo[i]   = regHit[i] && wrMask[0];
      assign strb.wrHi[i]   = regHit[i] && wrMask[1];
    end
  endgenerate

  // a write to the count overrides the tick
  assign strb.tickInc = tickEn && !(strb.wrLo[SEL_TIME] || strb.wrHi[SEL_TIME]);

  // R10: at most one register is targeted per cycle
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrLo | strb.wrHi));

  // R3: time write and tick together never produce an increment
  p_write_beats_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && wrEn && wrSel == SEL_W'(SEL_TIME) && wrMask != 2'b00) |-> !strb.tickInc);
endmodule

// File: rtl/htimer_datapath.sv
module htimer_datapath
  import htimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [TIME_W-1:0] wrData,
  output logic [TIME_W-1:0] timeQ,
  output logic              mtPend,
  output logic              stPend,
  output logic              vstPend
);
  logic [TIME_W-1:0] regQ [NUM_REGS];
  logic [TIME_W-1:0] effVsTime;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [TIME_W-1:0] RST_VAL =
        (i == SEL_TIME || i == SEL_OFFS) ? '0 : '1;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          regQ[i] <= RST_VAL;
        end else if (strb.wrLo[i] || strb.wrHi[i]) begin
          if (strb.wrLo[i]) regQ[i][HALF_W-1:0]      <= wrData[HALF_W-1:0];
          if (strb.wrHi[i]) regQ[i][TIME_W-1:HALF_W] <= wrData[TIME_W-1:HALF_W];
        end else if (i == SEL_TIME && strb.tickInc) begin
          regQ[i] <= regQ[i] + TIME_W'(1);
        end
      end
    end
  endgenerate

  assign timeQ     = regQ[SEL_TIME];
  assign effVsTime = regQ[SEL_TIME] + regQ[SEL_OFFS];  // carry dropped
  assign mtPend    = regQ[SEL_TIME] >= regQ[SEL_MCMP];
  assign stPend    = regQ[SEL_TIME] >= regQ[SEL_SCMP];
  assign vstPend   = effVsTime      >= regQ[SEL_VSCMP];

  // R2: a tick advances the count by one
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.tickInc |=> timeQ == $past(timeQ) + TIME_W'(1));

  // R3: full write of the count loads the data exactly
  p_time_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLo[SEL_TIME] && strb.wrHi[SEL_TIME]) |=> timeQ == $past(wrData));

  // R10: without strobe or tick the count holds
  p_time_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrLo[SEL_TIME] || strb.wrHi[SEL_TIME] || strb.tickInc) |=> $stable(timeQ));

  // R9: a low-half write leaves the high half of the count alone
  p_half_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLo[SEL_TIME] && !strb.wrHi[SEL_TIME])
      |=> timeQ[TIME_W-1:HALF_W] == $past(timeQ[TIME_W-1:HALF_W]));
endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import htimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [1:0]        wrMask,
  input  logic [TIME_W-1:0] wrData,
  output logic [TIME_W-1:0] machTime,
  output logic [TIME_W-1:0] superTime,
  output logic              mPendMtimer,
  output logic              mPendStimer,
  output logic              sPendStimer,
  output logic              hPendVstimer
);
  strobe_t           strb;
  logic [TIME_W-1:0] timeQ;
  logic              mtPend, stPend, vstPend;

  htimer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrSel(wrSel), .wrMask(wrMask), .strb(strb)
  );

  htimer_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .timeQ(timeQ), .mtPend(mtPend), .stPend(stPend), .vstPend(vstPend)
  );

  assign machTime     = timeQ;
  assign superTime    = timeQ;
  assign mPendMtimer  = mtPend;
  assign mPendStimer  = stPend;
  assign sPendStimer  = stPend;
  assign hPendVstimer = vstPend;

  // R1: one cycle out of reset the count is zero and nothing is pending
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rstN) && rstN |-> (machTime == '0 && !mPendMtimer && !sPendStimer && !hPendVstimer));
endmodule

// File: tb/hart_timer_unit_bench.sv
`timescale 1ns/1ps
module hart_timer_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [1:0]  wrMask = '0;
  logic [63:0] wrData = '0;
  logic [63:0] machTime, superTime;
  logic        mPendMtimer, mPendStimer, sPendStimer, hPendVstimer;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  hart_timer_unit u_hart_timer_unit (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrMask(wrMask), .wrData(wrData), .machTime(machTime), .superTime(superTime),
    .mPendMtimer(mPendMtimer), .mPendStimer(mPendStimer),
    .sPendStimer(sPendStimer), .hPendVstimer(hPendVstimer)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  mask;
    logic        tick;
    logic [63:0] data;
    logic [63:0] expTime;
    logic        expM;
    logic        expS;
    logic        expV;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 2'b11, 1'b0, 64'd100, 64'd0, 1'b0, 1'b0, 1'b0},           // mcmp=100
    '{3'd2, 2'b11, 1'b0, 64'd50,  64'd0, 1'b0, 1'b0, 1'b0},           // scmp=50
    '{3'd3, 2'b11, 1'b0, 64'd200, 64'd0, 1'b0, 1'b0, 1'b0},           // vscmp=200
    '{3'd0, 2'b11, 1'b0, 64'd60,  64'd60, 1'b0, 1'b1, 1'b0},          // R8 time only
    '{3'd0, 2'b11, 1'b0, 64'd150, 64'd150, 1'b1, 1'b1, 1'b0},         // R8 R4
    '{3'd4, 2'b11, 1'b0, 64'd60,  64'd150, 1'b1, 1'b1, 1'b1},         // R6 offset
    '{3'd3, 2'b11, 1'b0, 64'd300, 64'd150, 1'b1, 1'b1, 1'b0},         // R11 vs clear
    '{3'd1, 2'b11, 1'b0, 64'd151, 64'd150, 1'b0, 1'b1, 1'b0},         // R11 m clear
    '{3'd0, 2'b00, 1'b1, 64'd0,   64'd151, 1'b1, 1'b1, 1'b0},         // R2 tick, R4 equal
    '{3'd0, 2'b11, 1'b1, 64'd10,  64'd10, 1'b0, 1'b0, 1'b0},          // R3 write beats tick
    '{3'd4, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 1'b0, 1'b0, 1'b0}, // R6 eff=9
    '{3'd3, 2'b11, 1'b0, 64'd5,   64'd10, 1'b0, 1'b0, 1'b1},          // R6 9>=5
    '{3'd3, 2'b11, 1'b0, 64'd20,  64'd10, 1'b0, 1'b0, 1'b0},          // R6 wrap 9<20
    '{3'd0, 2'b10, 1'b0, 64'h0000_0001_DEAD_BEEF, 64'h0000_0001_0000_000A, 1'b1, 1'b1, 1'b1}, // R9 hi
    '{3'd0, 2'b01, 1'b0, 64'h0000_0007_0000_0005, 64'h0000_0001_0000_0005, 1'b1, 1'b1, 1'b1}, // R9 lo
    '{3'd5, 2'b11, 1'b0, 64'd0,   64'h0000_0001_0000_0005, 1'b1, 1'b1, 1'b1}, // R10 bad sel
    '{3'd0, 2'b00, 1'b0, 64'd0,   64'h0000_0001_0000_0005, 1'b1, 1'b1, 1'b1}, // R10 zero mask
    '{3'd1, 2'b10, 1'b0, 64'h0000_0002_0000_0000, 64'h0000_0001_0000_0005, 1'b0, 1'b1, 1'b1} // R9 cmp hi
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input logic [63:0] eT, input logic eM, input logic eS, input logic eV, input string tag);
    check(machTime == eT, {tag, " R2/R3/R9 time"}, machTime, eT);
    check(superTime == machTime, {tag, " R7 superTime"}, superTime, machTime);
    check(mPendMtimer == eM, {tag, " R4 mtimer"}, 64'(mPendMtimer), 64'(eM));
    check(mPendStimer == eS && sPendStimer == eS, {tag, " R5 stimer views"},
          {62'd0, mPendStimer, sPendStimer}, {62'd0, eS, eS});
    check(hPendVstimer == eV, {tag, " R6 vstimer"}, 64'(hPendVstimer), 64'(eV));
  endtask

  task automatic step(input logic [2:0] s, input logic [1:0] m, input logic t,
                      input logic [63:0] d, input logic w);
    @(negedge clk);
    wrSel = s; wrMask = m; tickEn = t; wrData = d; wrEn = w;
    @(posedge clk);
    #1;
    wrEn = 1'b0; tickEn = 1'b0; wrMask = '0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    checkAll(64'd0, 1'b0, 1'b0, 1'b0, "R1 reset");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].sel, VEC[i].mask, VEC[i].tick, VEC[i].data,
           !(VEC[i].mask == 2'b00 && VEC[i].tick));
      checkAll(VEC[i].expTime, VEC[i].expM, VEC[i].expS, VEC[i].expV, $sformatf("vec%0d", i));
    end

    // R2 several consecutive ticks
    step(3'd0, 2'b11, 1'b0, 64'd500, 1'b1);
    for (int k = 0; k < 4; k++) step(3'd0, 2'b00, 1'b1, 64'd0, 1'b0);
    check(machTime == 64'd504, "R2 four ticks", machTime, 64'd504);

    // R2 wrap and R4 equality at all-ones
    step(3'd1, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    step(3'd0, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    check(mPendMtimer == 1'b1, "R4 equal at all-ones", 64'(mPendMtimer), 64'd1);
    step(3'd0, 2'b00, 1'b1, 64'd0, 1'b0);
    check(machTime == 64'd0, "R2 wrap to zero", machTime, 64'd0);
    check(mPendMtimer == 1'b0, "R4 after wrap", 64'(mPendMtimer), 64'd0);

    // R1 reset again mid-run restores compares
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    step(3'd0, 2'b11, 1'b0, 64'd1000, 1'b1);
    checkAll(64'd1000, 1'b0, 1'b0, 1'b0, "R1 compares all-ones after reset");

    finishRun();
  end
endmodule